// File: doc/BRIEF.md
# UART Interrupt Enable and Identification Unit

This unit holds the interrupt enable register of a 16550-style UART with extended features. It combines the individual interrupt source conditions into one request line and a prioritised identification byte. A simple register bus writes the enable register, and it reads either the enable register or the identification register. The rest of the UART supplies level conditions: receive data ready, transmit level below threshold, receive line error, modem status change, Xoff/special character seen and RTS/CTS change. It also supplies the FIFO-enable bit and the enhanced-feature write-enable bit. The unit stores the sleep-mode enable and exports it; it does not act on it.

Receive, line-status and modem sources are pending while their condition is active and their enable is set. The transmit source is an event. It is set when the transmit level enters the below-threshold condition while the transmit enable is on. It is cleared by a transmit load strobe, or by reading the identification register while the transmit source is the one being reported. Turning the transmit enable on while the level is already below threshold creates no event.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00, the identification register reads 0x01, `irq` is 0 and `sleep_en` is 0.
- R2: A write at address 0 always updates enable bits 3..0. Bits 7..4 update only when `feat_wen` is 1 and otherwise keep their value.
- R3: Enable bit 4 is driven out on `sleep_en`. Enable bit 0 gates receive ready, bit 1 transmit, bit 2 line status and bit 3 modem status.
- R4: Setting enable bit 1 while `src_tx_below` is already 1 raises no transmit event.
- R5: Identification bit 0 is 0 while any enabled source is pending and 1 otherwise, and `irq` is always its inverse.
- R6: Identification bits 7 and 6 both equal `fifo_en`, bit 5 equals `src_rtscts_chg` and bit 4 equals `src_xoff_det`. Bits 5 and 4 do not affect bit 0 or `irq`.
- R7: Identification bits 3..1 give the highest-priority pending source: line status 011 over receive ready 010 over transmit 001 over modem 000. They read 000 when nothing is pending.
- R8: Receive ready, line status and modem status are pending exactly while their input is 1 and their enable bit is 1.
- R9: A source whose enable bit is 0 never contributes to the pending state or to the code, even while its input is 1.
- R10: The transmit event is set one cycle after `src_tx_below` rises while enable bit 1 is 1. A `tx_load` pulse clears it. An identification read (`bus_rd` at address 1) clears it only when code 001 is reported.
- R11: When a transmit rise and a clear fall in the same cycle, the event ends up set.
- R12: `bus_addr` 0 reads the enable register and 1 reads the identification register. A write at address 1 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on identification read) |
| bus_addr | input | 1 | 0 = enable register, 1 = identification register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| feat_wen | input | 1 | Enhanced-feature write enable for enable bits 7..4 |
| fifo_en | input | 1 | FIFO enable, mirrored in identification bits 7..6 |
| src_rx_ready | input | 1 | Receive data ready condition |
| src_tx_below | input | 1 | Transmit level below threshold |
| src_line_err | input | 1 | Receive line status error |
| src_modem_chg | input | 1 | Modem status change |
| src_xoff_det | input | 1 | Xoff or special character detected |
| src_rtscts_chg | input | 1 | RTS/CTS low-to-high change |
| tx_load | input | 1 | Transmit holding register write strobe |
| irq | output | 1 | Interrupt request |
| sleep_en | output | 1 | Stored sleep-mode enable |

## Verification
The transmit event's set path and its clear paths can land on the same clock edge. The bench provokes this by raising `src_tx_below` in the cycle that `tx_load` pulses, and then reading back code 001 to judge that the set wins. It also issues an identification read while a line error outranks a pending transmit event. The event must survive that read and be reported once the line error drops. Both cases go through a scoreboard that compares read data and `irq` against values predicted from the requirements.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int DW    = 8;
  localparam int NSRC  = 4;   // pending vector: 0 modem, 1 tx, 2 rx, 3 line
  localparam int IDW   = 3;

  localparam logic [IDW-1:0] ID_MODEM = 3'b000;
  localparam logic [IDW-1:0] ID_TX    = 3'b001;
  localparam logic [IDW-1:0] ID_RX    = 3'b010;
  localparam logic [IDW-1:0] ID_LINE  = 3'b011;

  localparam int P_MODEM = 0;
  localparam int P_TX    = 1;
  localparam int P_RX    = 2;
  localparam int P_LINE  = 3;

  // highest priority wins; modem code doubles as "nothing pending"
  function automatic logic [IDW-1:0] pick_id(input logic [NSRC-1:0] pend);
    if (pend[P_LINE])     return ID_LINE;
    else if (pend[P_RX])  return ID_RX;
    else if (pend[P_TX])  return ID_TX;
    else                  return ID_MODEM;
  endfunction

  function automatic logic [DW-1:0] pack_ident(input logic fifo, input logic rts,
                                               input logic xoff, input logic [IDW-1:0] id,
                                               input logic any);
    return {fifo, fifo, rts, xoff, id, ~any};
  endfunction
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int DW       = 8,
  parameter int LOCK_LSB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          feat_wen,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ena
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    logic upd;
    if (i >= LOCK_LSB) begin : g_locked
      assign upd = wr_en & feat_wen;
    end else begin : g_open
      assign upd = wr_en;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ena[i] <= 1'b0;
      else if (upd) ena[i] <= wdata[i];
    end
  end

  // R2
  upper_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && feat_wen)) |=> (ena[DW-1:LOCK_LSB] == $past(ena[DW-1:LOCK_LSB])));
  // R2
  lower_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ena[LOCK_LSB-1:0] == $past(wdata[LOCK_LSB-1:0])));
endmodule

// File: rtl/irq_pending.sv
module irq_pending
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_en,   // 0 rx, 1 tx, 2 line, 3 modem (enable layout)
  input  logic            rx_ready,
  input  logic            tx_below,
  input  logic            line_err,
  input  logic            modem_chg,
  input  logic            tx_clr,
  output logic            tx_rise,
  output logic [NSRC-1:0] pend
);
  logic tx_below_q;
  logic tx_evt;

  assign tx_rise = src_en[1] & tx_below & ~tx_below_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_below_q <= 1'b0;
      tx_evt     <= 1'b0;
    end else begin
      tx_below_q <= tx_below;
      if (tx_rise)                  tx_evt <= 1'b1;
      else if (tx_clr || !src_en[1]) tx_evt <= 1'b0;
    end
  end

  always_comb begin
    pend          = '0;
    pend[P_RX]    = src_en[0] & rx_ready;
    pend[P_TX]    = src_en[1] & tx_evt;
    pend[P_LINE]  = src_en[2] & line_err;
    pend[P_MODEM] = src_en[3] & modem_chg;
  end

  // R11
  tx_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rise |=> tx_evt);
  // R4
  tx_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_evt && !tx_rise) |=> !tx_evt);
  // R10
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_clr && !tx_rise) |=> !tx_evt);
endmodule

// File: rtl/irq_ident.sv
module irq_ident
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend,
  input  logic            fifo_en,
  input  logic            xoff_det,
  input  logic            rtscts_chg,
  output logic [IDW-1:0]  id,
  output logic            any,
  output logic [DW-1:0]   ident
);
  assign any   = |pend;
  assign id    = pick_id(pend);
  assign ident = pack_ident(fifo_en, rtscts_chg, xoff_det, id, any);

  // R7
  line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend[P_LINE] |-> (ident[3:1] == ID_LINE));
  // R7
  idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> (ident[3:0] == 4'b0001));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic          bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          feat_wen,
  input  logic          fifo_en,
  input  logic          src_rx_ready,
  input  logic          src_tx_below,
  input  logic          src_line_err,
  input  logic          src_modem_chg,
  input  logic          src_xoff_det,
  input  logic          src_rtscts_chg,
  input  logic          tx_load,
  output logic          irq,
  output logic          sleep_en
);
  localparam logic ADDR_ENA   = 1'b0;
  localparam logic ADDR_IDENT = 1'b1;
  localparam int   SLEEP_BIT  = 4;

  logic [DW-1:0]   ena;
  logic [NSRC-1:0] pend;
  logic [IDW-1:0]  id;
  logic            any;
  logic [DW-1:0]   ident;
  logic            tx_rise;
  logic            ena_wr;
  logic            ident_rd;
  logic            tx_clr;

  assign ena_wr   = bus_wr & (bus_addr == ADDR_ENA);
  assign ident_rd = bus_rd & (bus_addr == ADDR_IDENT);
  assign tx_clr   = tx_load | (ident_rd & (id == ID_TX) & pend[P_TX]);

  irq_enable_reg #(.DW(DW), .LOCK_LSB(4)) u_ena (
    .clk(clk), .rst_n(rst_n), .wr_en(ena_wr), .feat_wen(feat_wen),
    .wdata(bus_wdata), .ena(ena)
  );

  irq_pending u_pend (
    .clk(clk), .rst_n(rst_n), .src_en(ena[NSRC-1:0]),
    .rx_ready(src_rx_ready), .tx_below(src_tx_below), .line_err(src_line_err),
    .modem_chg(src_modem_chg), .tx_clr(tx_clr), .tx_rise(tx_rise), .pend(pend)
  );

  irq_ident u_ident (
    .clk(clk), .rst_n(rst_n), .pend(pend), .fifo_en(fifo_en),
    .xoff_det(src_xoff_det), .rtscts_chg(src_rtscts_chg),
    .id(id), .any(any), .ident(ident)
  );

  assign bus_rdata = (bus_addr == ADDR_IDENT) ? ident : ena;
  assign irq       = any;
  assign sleep_en  = ena[SLEEP_BIT];

  // R5
  irq_vs_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ~ident[0]);
  // R9
  disabled_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ena[0] |-> (ident[3:1] != ID_RX));
  // R6
  mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ident[7:4] == {fifo_en, fifo_en, src_rtscts_chg, src_xoff_det});
endmodule

// File: tb/tb_uart_irq_ctrl.sv
module tb_uart_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0, bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic feat_wen = 0, fifo_en = 0;
  logic src_rx_ready = 0, src_tx_below = 0, src_line_err = 0, src_modem_chg = 0;
  logic src_xoff_det = 0, src_rtscts_chg = 0, tx_load = 0;
  logic irq, sleep_en;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [8:0] exp_q[$];
  string      tag_q[$];
  event       obs_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ctrl dut (.*);

  // expected identification byte restated from R5..R7
  function automatic logic [7:0] model_ident(input logic fifo, input logic rts, input logic xoff,
                                             input logic line, input logic rx, input logic tx,
                                             input logic modem);
    logic [2:0] code;
    logic none;
    none = !(line || rx || tx || modem);
    case (1'b1)
      line:    code = 3'd3;
      rx:      code = 3'd2;
      tx:      code = 3'd1;
      default: code = 3'd0;
    endcase
    return {fifo, fifo, rts, xoff, code, none};
  endfunction

  // monitor: pops the expected item and compares with the ports
  initial begin
    forever begin
      @(obs_ev);
      #1;
      begin
        logic [8:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_run++;
        if ({irq, bus_rdata} !== e) begin
          n_fail++;
          $display("FAIL %s: got irq=%b data=%h, expected irq=%b data=%h",
                   t, irq, bus_rdata, e[8], e[7:0]);
        end
      end
    end
  end

  // driver side of the scoreboard
  task automatic expect_rd(input logic a, input logic [7:0] d, input logic i, input string t);
    bus_addr = a;
    exp_q.push_back({i, d});
    tag_q.push_back(t);
    ->obs_ev;
    #2;
  endtask

  task automatic chk_bit(input logic act, input logic e, input string t);
    n_run++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: got %b, expected %b", t, act, e);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input logic a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 0;
  endtask

  task automatic rd_ident();
    bus_rd = 1; bus_addr = 1;
    tick();
    bus_rd = 0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    expect_rd(0, 8'h00, 0, "R1 enable reset");
    expect_rd(1, 8'h01, 0, "R1 ident reset");
    chk_bit(sleep_en, 0, "R1 sleep reset");

    // R2 upper nibble locked without feature enable
    wr(0, 8'hFF);
    expect_rd(0, 8'h0F, 0, "R2 locked upper");
    feat_wen = 1;
    wr(0, 8'h10);
    expect_rd(0, 8'h10, 0, "R2 unlocked upper");
    chk_bit(sleep_en, 1, "R3 sleep bit");

    // R6 fifo mirror
    fifo_en = 1;
    expect_rd(1, model_ident(1,0,0,0,0,0,0), 0, "R6 fifo mirror");
    fifo_en = 0;

    // R9 disabled sources
    src_rx_ready = 1; src_line_err = 1; src_modem_chg = 1;
    tick();
    expect_rd(1, model_ident(0,0,0,0,0,0,0), 0, "R9 disabled sources");

    // R7/R8 priority walk
    wr(0, 8'h1D);
    expect_rd(1, model_ident(0,0,0,1,1,0,1), 1, "R7 line first");
    src_line_err = 0;
    expect_rd(1, model_ident(0,0,0,0,1,0,1), 1, "R7 rx second");
    src_rx_ready = 0;
    expect_rd(1, model_ident(0,0,0,0,0,0,1), 1, "R8 modem code 000");
    src_modem_chg = 0;
    expect_rd(1, model_ident(0,0,0,0,0,0,0), 0, "R5 none pending");

    // R4 enabling while already below
    src_tx_below = 1;
    tick(); tick();
    wr(0, 8'h1F);
    tick(); tick();
    expect_rd(1, model_ident(0,0,0,0,0,0,0), 0, "R4 no spurious tx");

    // R10 rise sets, ident read clears
    src_tx_below = 0; tick();
    src_tx_below = 1; tick();
    expect_rd(1, model_ident(0,0,0,0,0,1,0), 1, "R10 tx rise");
    rd_ident();
    expect_rd(1, model_ident(0,0,0,0,0,0,0), 0, "R10 read clear");

    // R10 load clears
    src_tx_below = 0; tick();
    src_tx_below = 1; tick();
    expect_rd(1, model_ident(0,0,0,0,0,1,0), 1, "R10 tx rise again");
    tx_load = 1; tick(); tx_load = 0;
    expect_rd(1, model_ident(0,0,0,0,0,0,0), 0, "R10 load clear");

    // R11 set and load in the same cycle
    src_tx_below = 0; tick();
    src_tx_below = 1; tx_load = 1; tick(); tx_load = 0;
    expect_rd(1, model_ident(0,0,0,0,0,1,0), 1, "R11 set beats clear");

    // R10 read while line reported leaves tx
    src_line_err = 1;
    expect_rd(1, model_ident(0,0,0,1,0,1,0), 1, "R7 line over tx");
    rd_ident();
    src_line_err = 0;
    expect_rd(1, model_ident(0,0,0,0,0,1,0), 1, "R10 tx kept after line read");

    // R6 extended bits
    src_xoff_det = 1; src_rtscts_chg = 1;
    expect_rd(1, model_ident(0,1,1,0,0,1,0), 1, "R6 ext bits with tx");
    tx_load = 1; tick(); tx_load = 0;
    expect_rd(1, model_ident(0,1,1,0,0,0,0), 0, "R6 ext bits no irq");
    src_xoff_det = 0; src_rtscts_chg = 0;

    // R2/R12 lock again, write to ident ignored
    feat_wen = 0;
    wr(0, 8'hE0);
    expect_rd(0, 8'h10, 0, "R2 low cleared upper kept");
    wr(1, 8'hFF);
    expect_rd(0, 8'h10, 0, "R12 ident write ignored");
    expect_rd(1, model_ident(0,0,0,0,0,0,0), 0, "R12 ident unchanged");

    tick();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule